// File: doc/BRIEF.md
# Single-Byte SPI Master with Per-Transfer Mode and Collision Recovery

This block is a serial peripheral interface master that moves one byte in each direction per transfer. A one-cycle `start` pulse in idle captures the transmit byte and the clock polarity and phase inputs. The captured mode governs the whole transfer, so consecutive transfers can use any of the four SPI modes. The serial clock runs at half the system clock rate: it toggles once per system cycle, so each data bit takes two cycles. Bits go out most significant first. Chip select is left to the surrounding logic.

The controller steps through four states, encoded in 3 bits: idle (0), a leading-edge phase (2), a sampling phase (3) and an error state (6). A `start` pulse that arrives while a transfer is running does not queue a new transfer. It aborts the current one into the error state. That state lasts one cycle, parks the serial clock at its idle level, and then returns to idle with `busy` low.

Top module: `spi_byte_master`

## Requirements
- R1: A `start` sampled high in idle makes `busy` high from the next cycle for exactly 16 system cycles. `busy` is low in the cycle after that.
- R2: While `busy` is low after a transfer, `sclk` rests at the polarity captured for that transfer: 0 for `cpol`=0 and 1 for `cpol`=1.
- R3: `cpol`, `cpha` and `tx_byte` are captured only when `start` is accepted. Changing them during a transfer does not alter the byte sent, the byte received or the clock behaviour.
- R4: With `cpha`=0, `mosi` carries bit 7 before the first `sclk` edge and changes on each trailing edge. A slave that samples `mosi` on the leading edges recovers `tx_byte`, most significant bit first.
- R5: With `cpha`=1, `mosi` changes on each leading edge. A slave that samples `mosi` on the trailing edges recovers `tx_byte`, most significant bit first.
- R6: After a transfer, `rx_byte` equals the byte the slave shifted out on `miso`, most significant bit first, in all four modes. `miso` is sampled on the leading edge when `cpha`=0 and on the trailing edge when `cpha`=1.
- R7: A complete transfer produces exactly 16 `sclk` transitions (8 pulses), one per system cycle while `busy` is high.
- R8: A `start` sampled high while a transfer is running moves the machine to the error state for one cycle. `busy` is high in that cycle and low in the cycle after.
- R9: On an abort, `sclk` returns to the captured idle level in the error cycle, and `rx_byte` keeps the value it had before the aborting `start` was sampled.
- R10: A `start` that is still high during the error cycle is ignored. The machine returns to idle, and `busy` stays low afterwards unless a new `start` arrives.
- R11: After reset, `busy`, `sclk`, `mosi` and `rx_byte` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Transfer request, sampled on each rising clock edge |
| cpol | input | 1 | Clock polarity for the next transfer |
| cpha | input | 1 | Clock phase for the next transfer |
| tx_byte | input | 8 | Byte to send |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| rx_byte | output | 8 | Received byte, written bit by bit |
| busy | output | 1 | High while a transfer or an error recovery is in progress |

## Verification
The stimulus is applied on a falling edge, so the accepting rising edge follows half a cycle later. `busy` reacts in the next sample. The first leading `sclk` edge comes one cycle after acceptance, and `rx_byte` and the slave model's captured byte are complete 16 cycles after acceptance, the same sample in which `busy` is first seen low. An aborting `start` shows its effect one sample later: `busy` is still high, `sclk` is idle and `rx_byte` is frozen. `busy` is low one sample after that. The slave model acts 1 ns after each rising edge, and all bench checks run on falling edges, so every read happens after the register that produces the value has updated.

// File: rtl/spim_pkg.sv
// Shared definitions for the single-byte SPI master.
// Assumes the controller state fits in 3 bits with fixed code values.
package spim_pkg;

    // Controller states; the code values are fixed and part of the contract.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LEAD   = 3'd2,
        ST_SAMPLE = 3'd3,
        ST_ERROR  = 3'd6
    } spim_state_e;

endpackage

// File: rtl/spim_seq.sv
// Transfer sequencer: holds the state, the bit index and the captured mode.
// It issues one-cycle step strobes to the clock and data units.
// Assumes start is synchronous to clk; a start seen mid-transfer aborts.
module spim_seq
    import spim_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cpol_in,
    input  logic             cpha_in,
    output spim_state_e      state_o,
    output logic [CNT_W-1:0] bit_idx_o,
    output logic             pol_q_o,
    output logic             pha_q_o,
    output logic             accept_o,
    output logic             lead_go_o,
    output logic             trail_go_o,
    output logic             last_o
);

    localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(DATA_W - 1);

    spim_state_e      state_q, state_d;
    logic [CNT_W-1:0] idx_q;
    logic             pol_q, pha_q;

    assign last_o     = (idx_q == '0);
    assign accept_o   = (state_q == ST_IDLE) && start;
    assign lead_go_o  = (state_q == ST_LEAD) && !start;
    assign trail_go_o = (state_q == ST_SAMPLE) && !start;

    // Next-state selection; any start while shifting diverts to ST_ERROR.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (start) state_d = ST_LEAD;
            ST_LEAD:   state_d = start ? ST_ERROR : ST_SAMPLE;
            ST_SAMPLE: begin
                if (start)       state_d = ST_ERROR;
                else if (last_o) state_d = ST_IDLE;
                else             state_d = ST_LEAD;
            end
            ST_ERROR:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bit index: loads the MSB position on accept, steps down after each trailing phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                      idx_q <= '0;
        else if (accept_o)               idx_q <= TOP_IDX;
        else if (trail_go_o && !last_o)  idx_q <= idx_q - 1'b1;
    end

    // Mode capture: polarity and phase are frozen when a transfer is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= 1'b0;
            pha_q <= 1'b0;
        end else if (accept_o) begin
            pol_q <= cpol_in;
            pha_q <= cpha_in;
        end
    end

    assign state_o   = state_q;
    assign bit_idx_o = idx_q;
    assign pol_q_o   = pol_q;
    assign pha_q_o   = pha_q;

endmodule

// File: rtl/spim_sclk.sv
// Serial clock generator: drives the idle level outside transfers and toggles once per
// shifting phase. Assumes the sequencer strobes are mutually exclusive.
module spim_sclk (
    input  logic clk,
    input  logic rst_n,
    input  logic cpol_in,
    input  logic pol_q,
    input  logic accept,
    input  logic lead_go,
    input  logic trail_go,
    input  logic to_idle,
    output logic sclk_o
);

    logic sclk_q;

    // Clock level register: active level on leading steps, idle level otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                    sclk_q <= 1'b0;
        else if (accept)               sclk_q <= cpol_in;
        else if (lead_go)              sclk_q <= ~pol_q;
        else if (trail_go || to_idle)  sclk_q <= pol_q;
    end

    assign sclk_o = sclk_q;

endmodule

// File: rtl/spim_datapath.sv
// Data path: holds the transmit byte and drives mosi. Writes each received bit into the
// receive register at the current bit index. Assumes bit_idx counts down from the MSB.
module spim_datapath #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              lead_go,
    input  logic              trail_go,
    input  logic              last,
    input  logic              pha_q,
    input  logic              cpha_in,
    input  logic [DATA_W-1:0] tx_in,
    input  logic [CNT_W-1:0]  bit_idx,
    input  logic              miso,
    output logic              mosi_o,
    output logic [DATA_W-1:0] rx_o
);

    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              mosi_q;
    logic [CNT_W-1:0]  nxt_idx;
    logic              shift_out;
    logic              sample_in;

    assign nxt_idx = bit_idx - 1'b1;
    // Phase 0 shifts on trailing steps and samples on leading steps; phase 1 does the reverse.
    assign shift_out = pha_q ? lead_go : (trail_go && !last);
    assign sample_in = pha_q ? trail_go : lead_go;

    // Transmit byte holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)      tx_q <= '0;
        else if (accept) tx_q <= tx_in;
    end

    // mosi driver: presets the MSB for phase 0, then follows the shift steps.
    always_ff @(posedge clk) begin
        if (!rst_n)                     mosi_q <= 1'b0;
        else if (accept && !cpha_in)    mosi_q <= tx_in[DATA_W-1];
        else if (shift_out && pha_q)    mosi_q <= tx_q[bit_idx];
        else if (shift_out)             mosi_q <= tx_q[nxt_idx];
    end

    // Receive register: one bit written per sampling step, other bits hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_q <= '0;
        else if (sample_in) rx_q[bit_idx] <= miso;
    end

    assign mosi_o = mosi_q;
    assign rx_o   = rx_q;

endmodule

// File: rtl/spi_byte_master.sv
// Top of the single-byte SPI master. Wires the sequencer, clock generator and data path.
// Assumes one byte per transfer and an sclk of half the system clock rate.
module spi_byte_master
    import spim_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_byte,
    output logic              busy
);

    localparam int CNT_W = $clog2(DATA_W);

    spim_state_e      state;
    logic [CNT_W-1:0] bit_idx;
    logic             mode_cpol, mode_cpha;
    logic             accept, lead_go, trail_go, last_bit;
    logic             to_idle;

    // A start while shifting sends sclk back to its idle level.
    assign to_idle = start && (state == ST_LEAD || state == ST_SAMPLE);
    assign busy    = (state != ST_IDLE);

    spim_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cpol_in    (cpol),
        .cpha_in    (cpha),
        .state_o    (state),
        .bit_idx_o  (bit_idx),
        .pol_q_o    (mode_cpol),
        .pha_q_o    (mode_cpha),
        .accept_o   (accept),
        .lead_go_o  (lead_go),
        .trail_go_o (trail_go),
        .last_o     (last_bit)
    );

    spim_sclk u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpol_in  (cpol),
        .pol_q    (mode_cpol),
        .accept   (accept),
        .lead_go  (lead_go),
        .trail_go (trail_go),
        .to_idle  (to_idle),
        .sclk_o   (sclk)
    );

    spim_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .lead_go  (lead_go),
        .trail_go (trail_go),
        .last     (last_bit),
        .pha_q    (mode_cpha),
        .cpha_in  (cpha),
        .tx_in    (tx_byte),
        .bit_idx  (bit_idx),
        .miso     (miso),
        .mosi_o   (mosi),
        .rx_o     (rx_byte)
    );

endmodule

// File: rtl/spim_checker.sv
// Property checker for spi_byte_master, attached by bind. It observes ports and the
// state and mode registers; it drives nothing.
module spim_checker
    import spim_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              sclk,
    input logic [DATA_W-1:0] rx_byte,
    input spim_state_e       state,
    input logic              mode_cpol
);

    // R1: an accepted start raises busy in the next cycle.
    assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R2: while idle, sclk sits at the captured polarity.
    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> (sclk == mode_cpol));

    // R3: the captured polarity does not move while a transfer runs.
    assert_mode_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_cpol));

    // R7: each uninterrupted shifting phase toggles sclk.
    assert_sclk_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_LEAD || state == ST_SAMPLE) && !start) |=> (sclk != $past(sclk)));

    // R8: a start while shifting goes to the error state.
    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_LEAD || state == ST_SAMPLE) && start) |=> (state == ST_ERROR));

    // R8, R10: the error state lasts one cycle, whatever start does.
    assert_error_short_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERROR) |=> (state == ST_IDLE && !busy));

    // R9: the error cycle shows the idle clock level and a frozen receive byte.
    assert_error_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERROR) |-> ($stable(rx_byte) && sclk == mode_cpol));

endmodule

bind spi_byte_master spim_checker #(.DATA_W(DATA_W)) u_spim_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .sclk      (sclk),
    .rx_byte   (rx_byte),
    .state     (state),
    .mode_cpol (mode_cpol)
);

// File: tb/test_spi_byte_master.sv
`timescale 1ns/1ps
module test_spi_byte_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       miso;
    logic       sclk, mosi, busy;
    logic [7:0] rx_byte;

    int n_checks = 0;
    int n_fails  = 0;

    // Slave model configuration, written by the stimulus only.
    logic       m_pol = 1'b0;
    logic       m_pha = 1'b0;
    logic [7:0] s_tx = 8'h00;
    int         xfer_id = 0;

    // Slave model state, written by the slave process only.
    int         seen_id = 0;
    logic       prev_sclk = 1'b0;
    int         shifts = 0;
    int         caps = 0;
    int         toggles = 0;
    logic [7:0] got = 8'h00;

    spi_byte_master i_spi_byte_master (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cpol    (cpol),
        .cpha    (cpha),
        .tx_byte (tx_byte),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .rx_byte (rx_byte),
        .busy    (busy)
    );

    always #5 clk = ~clk;

    function automatic int exp_busy_cycles();
        return 2 * 8;
    endfunction

    function automatic int exp_toggles();
        return 2 * 8;
    endfunction

    function automatic logic exp_idle(input logic pol);
        return pol;
    endfunction

    // Slave: acts 1 ns after each rising edge, shifts miso on shift edges, captures mosi on the others.
    always @(posedge clk) begin
        int idx;
        #1;
        if (xfer_id != seen_id) begin
            seen_id   = xfer_id;
            prev_sclk = m_pol;
            shifts    = 0;
            caps      = 0;
            toggles   = 0;
            got       = 8'h00;
        end else if (sclk != prev_sclk) begin
            toggles = toggles + 1;
            if ((sclk != m_pol) == m_pha) shifts = shifts + 1;
            else begin
                if (caps < 8) got[7 - caps] = mosi;
                caps = caps + 1;
            end
            prev_sclk = sclk;
        end
        idx  = m_pha ? 8 - shifts : 7 - shifts;
        miso = (idx >= 0 && idx <= 7) ? s_tx[idx] : 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Starts a transfer at the current falling edge; optionally scrambles the inputs afterwards.
    task automatic launch(input logic [7:0] t, input logic [7:0] s, input logic pol, input logic pha,
                          input bit scramble);
        tx_byte = t; cpol = pol; cpha = pha; start = 1'b1;
        m_pol = pol; m_pha = pha; s_tx = s; xfer_id++;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin
            cpol    = 1'($urandom);
            cpha    = 1'($urandom);
            tx_byte = 8'($urandom);
        end
    endtask

    task automatic run_xfer(input logic [7:0] t, input logic [7:0] s, input logic pol, input logic pha,
                            input bit scramble);
        int n = 0;
        launch(t, s, pol, pha, scramble);
        while (busy && n < 200) begin
            n++;
            @(negedge clk);
        end
        check(n == exp_busy_cycles(), "R1 busy length", n, exp_busy_cycles());
        check(rx_byte == s, "R6 received byte", rx_byte, s);
        check(got == t, pha ? "R5 sent byte" : "R4 sent byte", got, t);
        check(toggles == exp_toggles(), "R7 sclk transitions", toggles, exp_toggles());
        check(sclk == exp_idle(pol), "R2 idle level", sclk, exp_idle(pol));
        if (scramble)
            check(rx_byte == s && got == t, "R3 inputs changed mid-transfer", {rx_byte, got}, {s, t});
    endtask

    // Aborts a transfer with a start at falling edge k after acceptance (k in 1..16).
    task automatic run_abort(input int k, input logic pol, input logic pha, input bit hold2);
        logic [7:0] snap;
        launch(8'($urandom), 8'($urandom), pol, pha, 1'b0);
        repeat (k - 1) @(negedge clk);
        start = 1'b1;
        snap  = rx_byte;
        @(negedge clk);
        if (!hold2) start = 1'b0;
        check(busy == 1'b1, "R8 busy in error cycle", busy, 1);
        check(sclk == exp_idle(pol), "R9 sclk idle on abort", sclk, exp_idle(pol));
        check(rx_byte == snap, "R9 rx_byte held on abort", rx_byte, snap);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R8 busy low after error", busy, 0);
        if (hold2) begin
            @(negedge clk);
            check(busy == 1'b0 && rx_byte == snap, "R10 start in error ignored",
                  {busy, rx_byte}, {1'b0, snap});
            check(sclk == exp_idle(pol), "R10 sclk stays idle", sclk, exp_idle(pol));
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset values.
        check(busy == 1'b0 && sclk == 1'b0, "R11 busy/sclk after reset", {busy, sclk}, 0);
        check(mosi == 1'b0 && rx_byte == 8'h00, "R11 mosi/rx_byte after reset", {mosi, rx_byte}, 0);

        // Directed: every mode and the edge patterns.
        run_xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0);
        run_xfer(8'h5A, 8'hC3, 1'b0, 1'b1, 1'b0);
        run_xfer(8'h80, 8'h01, 1'b1, 1'b0, 1'b0);
        run_xfer(8'h01, 8'h80, 1'b1, 1'b1, 1'b0);
        run_xfer(8'hFF, 8'h00, 1'b1, 1'b0, 1'b0);
        run_xfer(8'h00, 8'hFF, 1'b0, 1'b1, 1'b0);

        // Random transfers, back to back or with gaps, with inputs scrambled mid-transfer.
        for (int i = 0; i < 40; i++) begin
            if ($urandom_range(1, 0) == 1) repeat ($urandom_range(3, 1)) @(negedge clk);
            run_xfer(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), i % 2 == 1);
        end

        // Aborts at the first and last possible cycle, then random points.
        run_abort(1, 1'b0, 1'b0, 1'b0);
        run_abort(16, 1'b1, 1'b1, 1'b0);
        run_abort(16, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 12; i++)
            run_abort($urandom_range(16, 1), 1'($urandom), 1'($urandom), i % 3 == 0);

        // A normal transfer still works after recovery.
        run_xfer(8'h96, 8'hF0, 1'b0, 1'b1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R1: watchdog expired, actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule